// File: doc/BRIEF.md
# Differential Clock Output Gate with Slow-Clock Float

This block sits behind a clock-distribution loop and drives six differential output pairs plus one feedback output from a single input clock. Each pair carries a true clock, its complement and an output-enable. A pair with its enable low is meant to be left floating by the pad ring. The enable bits come from two configuration bytes written elsewhere, in another clock domain. The block carries them into the input-clock domain. It lets an enable change only while the input clock is low, so a pair always starts or stops on a whole clock period.

A frequency monitor runs on a separate reference clock. It counts edges of a divided copy of the input clock over a fixed window. When the input clock is slower than a threshold, every output-enable drops, the feedback output included. A bypass strap overrides the monitor for test. In bypass the outputs keep following the input clock and obey only the per-pair enables.

Top module: `ddr_clk_out_gate`

## Requirements
- R1: Every true output and the feedback output carry the input clock level, and every complement output is its inverse.
- R2: A pair whose enable bit is 0 has its output-enable low, which requests high impedance on both its true and complement pins.
- R3: Enable bits map as follows. Byte `en_lo` bit 7 drives pair 0, bit 6 drives pair 1, bit 3 drives pair 2, bit 1 drives pair 4 and bit 2 drives pair 5. Byte `en_hi` bit 6 drives pair 3. Every other bit of both bytes has no effect.
- R4: A pair's output-enable changes only while the input clock is low. A configuration change reaches it after two rising edges and the falling edge that follows them.
- R5: While the slow-clock flag is set and bypass is low, every pair output-enable and the feedback output-enable are low.
- R6: The feedback output-enable does not depend on any enable bit.
- R7: With bypass high, the slow-clock flag has no effect: the feedback output is enabled and each pair follows its enable bit.
- R8: During reset all pairs are enabled. The slow-clock flag is set, and it stays set until the first measurement window after reset has been evaluated.
- R9: A single measurement window with fewer than `MIN_TOGGLES` divided-clock transitions sets the slow-clock flag.
- R10: Once the flag is set by a slow window, it clears only after two consecutive windows at or above the threshold, and only at a window end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to distribute |
| ref_clk | input | 1 | Reference clock for the frequency monitor |
| rst_n | input | 1 | Active-low asynchronous reset |
| bypass | input | 1 | Test strap; ignores the slow-clock monitor when high |
| en_lo | input | 8 | First configuration byte of pair enables |
| en_hi | input | 8 | Second configuration byte of pair enables |
| out_t | output | 6 | True clock of each pair |
| out_c | output | 6 | Complement clock of each pair |
| out_oe | output | 6 | Output-enable of each pair, 0 means high impedance |
| fb_out | output | 1 | Feedback clock |
| fb_oe | output | 1 | Feedback output-enable |

## Verification
On every cycle the assertions check four things. Pair enables hold steady through the high phase of the input clock. No pair is enabled while the feedback output floats. A slow window always sets the flag, and the flag clears only at a window boundary that passed the threshold. Bypass keeps the feedback live. The bench scenarios cover what spans long stretches of time. These are the byte-to-pair mapping and the reserved bits, the reset state, entering the float state at a 10 MHz input, and the two-window recovery after a return to 100 MHz.

// File: rtl/ddr_clk_out_gate.sv
module ddr_clk_out_gate #(
  parameter int REF_WINDOW  = 128,
  parameter int MIN_TOGGLES = 13,
  parameter int DIV_LOG2    = 3
) (
  input  logic       clk_in,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       bypass,
  input  logic [7:0] en_lo,
  input  logic [7:0] en_hi,
  output logic [5:0] out_t,
  output logic [5:0] out_c,
  output logic [5:0] out_oe,
  output logic       fb_out,
  output logic       fb_oe
);
  localparam int WCW = $clog2(REF_WINDOW + 1);
  localparam int TCW = $clog2(MIN_TOGGLES + 1);

  // pair enables gathered from the configuration bytes
  logic [5:0] en_raw;
  assign en_raw = {en_lo[2], en_lo[1], en_hi[6], en_lo[3], en_lo[6], en_lo[7]};

  logic [5:0] sync1, sync2, en_q, en_rise;
  logic [DIV_LOG2-1:0] div_cnt;

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n) begin
      sync1   <= '1;
      sync2   <= '1;
      en_rise <= '1;
      div_cnt <= '0;
    end else begin
      sync1   <= en_raw;
      sync2   <= sync1;
      en_rise <= en_q;
      div_cnt <= div_cnt + 1'b1;
    end

  always_ff @(negedge clk_in or negedge rst_n)
    if (!rst_n) en_q <= '1;
    else        en_q <= sync2;

  // frequency monitor in the reference domain
  logic [2:0]     tap_s;
  logic [WCW-1:0] win_cnt;
  logic [TCW-1:0] tog_cnt, tog_next;
  logic           slow_q, good_run, win_end, below, toggle;

  assign toggle   = tap_s[2] ^ tap_s[1];
  assign tog_next = tog_cnt + TCW'(toggle && (tog_cnt != TCW'(MIN_TOGGLES)));
  assign below    = tog_next < TCW'(MIN_TOGGLES);
  assign win_end  = win_cnt == WCW'(REF_WINDOW - 1);

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      tap_s    <= '0;
      win_cnt  <= '0;
      tog_cnt  <= '0;
      slow_q   <= 1'b1;
      good_run <= 1'b1;
    end else begin
      tap_s <= {tap_s[1:0], div_cnt[DIV_LOG2-1]};
      if (win_end) begin
        win_cnt <= '0;
        tog_cnt <= '0;
        if (below) begin
          slow_q   <= 1'b1;
          good_run <= 1'b0;
        end else begin
          if (good_run) slow_q <= 1'b0;
          good_run <= 1'b1;
        end
      end else begin
        win_cnt <= win_cnt + 1'b1;
        tog_cnt <= tog_next;
      end
    end

  logic live;
  assign live   = bypass | ~slow_q;
  assign out_t  = {6{clk_in}};
  assign out_c  = ~out_t;
  assign fb_out = clk_in;
  assign out_oe = en_q & {6{live}};
  assign fb_oe  = live;

  a_r4_no_runt: assert property (@(negedge clk_in) disable iff (!rst_n)
    en_q == en_rise);
  a_r5_float_all: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !fb_oe |-> out_oe == 6'd0);
  a_r9_bad_window: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (win_end && below) |=> slow_q);
  a_r10_clear_at_end: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(slow_q) |-> $past(win_end && !below));
  a_r7_bypass_live: assert property (@(posedge ref_clk) disable iff (!rst_n)
    bypass |-> fb_oe);
endmodule

// File: tb/ddr_clk_out_gate_tb.sv
`timescale 1ns/1ps
module ddr_clk_out_gate_tb;
  logic       ref_clk = 0, clk_in = 0, rst_n = 0, bypass = 0;
  logic [7:0] en_lo = 8'hFF, en_hi = 8'hFF;
  logic [5:0] out_t, out_c, out_oe;
  logic       fb_out, fb_oe;
  int         half_ns = 5;
  int         n_chk = 0, n_bad = 0, runt = 0;
  logic       mon_en = 0;

  ddr_clk_out_gate u_dut (.clk_in(clk_in), .ref_clk(ref_clk), .rst_n(rst_n),
    .bypass(bypass), .en_lo(en_lo), .en_hi(en_hi), .out_t(out_t), .out_c(out_c),
    .out_oe(out_oe), .fb_out(fb_out), .fb_oe(fb_oe));

  always #10 ref_clk = ~ref_clk;
  initial forever #(half_ns) clk_in = ~clk_in;

  always @(out_oe) if (mon_en && clk_in) runt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {en_lo, en_hi, expected out_oe}
  localparam logic [21:0] VEC [10] = '{
    {8'hFF, 8'hFF, 6'h3F}, {8'h00, 8'h00, 6'h00}, {8'h80, 8'h00, 6'h01},
    {8'h40, 8'h00, 6'h02}, {8'h08, 8'h00, 6'h04}, {8'h00, 8'h40, 6'h08},
    {8'h02, 8'h00, 6'h10}, {8'h04, 8'h00, 6'h20}, {8'h31, 8'hBF, 6'h00},
    {8'hCE, 8'h40, 6'h3F}};

  initial begin
    #100;
    chk("R8 reset pairs float while slow", {26'd0, out_oe}, 32'h0);
    chk("R8 reset fb floats", {31'd0, fb_oe}, 32'h0);
    bypass = 1; #5;
    chk("R8 reset all pairs enabled", {26'd0, out_oe}, 32'h3F);
    chk("R7 bypass fb live in reset", {31'd0, fb_oe}, 32'h1);
    bypass = 0;
    #200 rst_n = 1;
    #1000;
    chk("R8 slow until first window", {31'd0, fb_oe}, 32'h0);
    #2600;
    chk("R8 live after first window", {31'd0, fb_oe}, 32'h1);
    chk("R8 pairs enabled", {26'd0, out_oe}, 32'h3F);

    mon_en = 1;
    for (int i = 0; i < 10; i++) begin
      en_lo = VEC[i][21:14];
      en_hi = VEC[i][13:6];
      #203;
      chk("R3 mapping/R2 disable", {26'd0, out_oe}, {26'd0, VEC[i][5:0]});
      chk("R6 fb independent", {31'd0, fb_oe}, 32'h1);
      chk("R1 complement", {26'd0, out_c}, {26'd0, ~out_t});
      chk("R1 true follows", {26'd0, out_t}, {26'd0, {6{clk_in}}});
    end
    mon_en = 0;
    chk("R4 no enable change in high phase", runt, 0);

    en_lo = 8'hFF; en_hi = 8'hFF;
    half_ns = 50;
    #6000;
    chk("R9 slow sets fb float", {31'd0, fb_oe}, 32'h0);
    chk("R5 all pairs float", {26'd0, out_oe}, 32'h0);

    bypass = 1;
    for (int k = 0; k < 4; k++) begin
      #37;
      chk("R7 bypass fb on", {31'd0, fb_oe}, 32'h1);
      chk("R7 bypass pairs on", {26'd0, out_oe}, 32'h3F);
      chk("R7 bypass fb follows", {31'd0, fb_out}, {31'd0, clk_in});
      chk("R1 bypass complement", {26'd0, out_c}, {26'd0, {6{~clk_in}}});
    end
    bypass = 0; #1;
    chk("R5 float back without bypass", {31'd0, fb_oe}, 32'h0);

    half_ns = 5;
    #2400;
    chk("R10 one good window not enough", {31'd0, fb_oe}, 32'h0);
    #8000;
    chk("R10 cleared after two good windows", {31'd0, fb_oe}, 32'h1);
    chk("R10 pairs back", {26'd0, out_oe}, 32'h3F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule